// File: doc/BRIEF.md
# Multiplexed Two-Cycle Address Latch

This block sits on the device side of a flash bus where address and data share one 16-bit set of pins. A full word address is wider than the bus, so the host sends it as an upper half and a lower half in separate address cycles. The level of the output-enable strobe during each cycle says which half is on the pins. Low means upper and high means lower. The host may skip the upper cycle entirely. In that case the upper half from an earlier access stays in force, and only the lower half is replaced.

The block runs in one of two capture modes, picked by bit 15 of a configuration word. In asynchronous mode a half is taken when the address-valid strobe rises. In synchronous mode a half is taken on each rising clock edge while address-valid is low. This lets a host hold address-valid low and deliver both halves on two consecutive edges. Loading the lower half marks the end of the address phase. One clock later the block raises a one-cycle pulse that tells the array to start sensing. The assembled address is available continuously on its output.

All logic runs on the internal clock. In asynchronous mode the strobe edge is found by registering the bus pins and comparing the current strobe level with the registered one.

Top module: `multiplexed_addr_latch`

## Requirements
- R1: While rst_ni is low, addr_o is all zeros and sense_o is low. Both stay so after release until a capture occurs.
- R2: In synchronous mode (cfg_i[15] = 0), a rising clk_i edge with ce_n_i, adv_n_i and oe_n_i all low loads ad_i[9:0] into addr_o[25:16]. ad_i[15:10] are discarded, and addr_o[15:0] is left unchanged.
- R3: In synchronous mode, a rising clk_i edge with ce_n_i low, adv_n_i low and oe_n_i high loads ad_i into addr_o[15:0]. sense_o is then high for the one cycle following that edge.
- R4: In synchronous mode, adv_n_i may stay low across two consecutive edges. The first edge (oe_n_i low) loads the upper half and the second edge (oe_n_i high) loads the lower half.
- R5: In asynchronous mode (cfg_i[15] = 1), a capture happens at the first clock edge that sees adv_n_i high after an edge that saw it low. That capture uses the ad_i, oe_n_i and ce_n_i values from the last edge at which adv_n_i was low, and oe_n_i selects the half as in R2 and R3.
- R6: In asynchronous mode, a lower-half capture makes sense_o high for the one cycle after the capture edge.
- R7: A lower-half capture with no upper cycle before it keeps the previously loaded addr_o[25:16].
- R8: With ce_n_i high, no capture happens in either mode: addr_o does not change and sense_o stays low.
- R9: In asynchronous mode, clock edges during which adv_n_i stays low load nothing, whatever oe_n_i and ad_i are.
- R10: sense_o is low in every cycle that does not directly follow a lower-half capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock; also the synchronous-mode bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 16 | Configuration word; bit 15 = 1 selects asynchronous capture |
| ce_n_i | input | 1 | Chip enable, active low |
| adv_n_i | input | 1 | Address-valid strobe, active low |
| oe_n_i | input | 1 | Output enable; during an address cycle low = upper half, high = lower half |
| ad_i | input | 16 | Multiplexed address/data pins |
| addr_o | output | 26 | Assembled address {upper half, lower half} |
| sense_o | output | 1 | One-cycle start-of-sense pulse |

## Verification
The bench builds the block with its default parameters: a 26-bit address over a 16-bit bus and the mode flag at configuration bit 15. With these values the upper half is 10 bits wide. Driving ones on ad_i[15:10] during an upper cycle therefore shows directly on addr_o whether the surplus pins are dropped. A 16-bit configuration word lets the bench flip between the two modes on the same instance. It can then run the same upper/lower/single-lower sequences, and the chip-enable-high cases, under both capture rules.

// File: rtl/mal_pkg.sv
package mal_pkg;
  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_HI   = 2'd1,
    CAP_LO   = 2'd2
  } cap_kind_e;
endpackage

// File: rtl/mal_capture_ctl.sv
module mal_capture_ctl
  import mal_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int MODE_BIT = 15,
  parameter int BUS_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             ce_n_i,
  input  logic             adv_n_i,
  input  logic             oe_n_i,
  input  logic [BUS_W-1:0] ad_i,
  output cap_kind_e        kind_o,
  output logic [BUS_W-1:0] data_o
);
  logic             async_mode;
  logic             adv_q, oe_q, ce_q;
  logic [BUS_W-1:0] ad_q;
  logic             adv_rise;

  assign async_mode = cfg_i[MODE_BIT];

  // bus snapshot from the previous edge, used by the asynchronous path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_q <= 1'b1;
      oe_q  <= 1'b1;
      ce_q  <= 1'b1;
      ad_q  <= '0;
    end else begin
      adv_q <= adv_n_i;
      oe_q  <= oe_n_i;
      ce_q  <= ce_n_i;
      ad_q  <= ad_i;
    end
  end

  assign adv_rise = !adv_q && adv_n_i;

  always_comb begin
    kind_o = CAP_NONE;
    data_o = ad_i;
    if (async_mode) begin
      data_o = ad_q;
      if (adv_rise && !ce_q) kind_o = oe_q ? CAP_LO : CAP_HI;
    end else if (!ce_n_i && !adv_n_i) begin
      kind_o = oe_n_i ? CAP_LO : CAP_HI;
    end
  end
endmodule

// File: rtl/mal_half_latch.sv
module mal_half_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/multiplexed_addr_latch.sv
module multiplexed_addr_latch
  import mal_pkg::*;
#(
  parameter int ADDR_W   = 26,
  parameter int BUS_W    = 16,
  parameter int CFG_W    = 16,
  parameter int MODE_BIT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              ce_n_i,
  input  logic              adv_n_i,
  input  logic              oe_n_i,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sense_o
);
  localparam int HI_W = ADDR_W - BUS_W;

  cap_kind_e        kind;
  logic [BUS_W-1:0] cap_data;
  logic [HI_W-1:0]  hi_q;
  logic [BUS_W-1:0] lo_q;
  logic             cfg_unused;

  assign cfg_unused = ^cfg_i;

  mal_capture_ctl #(
    .CFG_W(CFG_W), .MODE_BIT(MODE_BIT), .BUS_W(BUS_W)
  ) u_ctl (
    .clk_i, .rst_ni, .cfg_i, .ce_n_i, .adv_n_i, .oe_n_i, .ad_i,
    .kind_o(kind), .data_o(cap_data)
  );

  mal_half_latch #(.W(HI_W)) u_hi (
    .clk_i, .rst_ni, .load_i(kind == CAP_HI),
    .d_i(cap_data[HI_W-1:0]), .q_o(hi_q)
  );

  mal_half_latch #(.W(BUS_W)) u_lo (
    .clk_i, .rst_ni, .load_i(kind == CAP_LO),
    .d_i(cap_data), .q_o(lo_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sense_o <= 1'b0;
    else         sense_o <= (kind == CAP_LO);
  end

  assign addr_o = {hi_q, lo_q};

  p_ce_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |=> (!ce_n_i || $stable(addr_o)));

  p_sync_sense_src_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_o && !$past(cfg_i[MODE_BIT])) |-> $past(!adv_n_i && oe_n_i && !ce_n_i));

  p_async_sense_src_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_o && $past(cfg_i[MODE_BIT])) |-> ($past(adv_n_i) && !$past(adv_n_i, 2)));

  p_upper_keep_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_o |-> (addr_o[ADDR_W-1:BUS_W] == $past(addr_o[ADDR_W-1:BUS_W])));
endmodule

// File: tb/tb_multiplexed_addr_latch.sv
module tb_multiplexed_addr_latch;
  typedef struct {
    logic [25:0] addr;
    logic        sense;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
  logic [15:0] ad = '0;
  logic [25:0] addr;
  logic        sense;

  int total = 0, bad = 0;
  exp_t q[$];

  // bench model state
  logic [9:0]  m_hi;
  logic [15:0] m_lo, m_ad_q;
  logic        m_adv_q, m_oe_q, m_ce_q;

  always #5 clk = ~clk;

  multiplexed_addr_latch dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_i(cfg), .ce_n_i(ce_n), .adv_n_i(adv_n),
    .oe_n_i(oe_n), .ad_i(ad), .addr_o(addr), .sense_o(sense)
  );

  task automatic check(string tag, logic [25:0] ga, logic gs, logic [25:0] ea, logic es);
    total++;
    if (ga !== ea || gs !== es) begin
      bad++;
      $display("FAIL %s: addr=%h sense=%b expected addr=%h sense=%b", tag, ga, gs, ea, es);
    end
  endtask

  task automatic model_reset();
    m_hi = '0; m_lo = '0; m_ad_q = '0;
    m_adv_q = 1'b1; m_oe_q = 1'b1; m_ce_q = 1'b1;
  endtask

  task automatic cyc(logic a, logic o, logic c, logic [15:0] d, string tag);
    exp_t e;
    logic s;
    @(negedge clk);
    adv_n = a; oe_n = o; ce_n = c; ad = d;
    s = 1'b0;
    if (cfg[15]) begin
      if (!m_adv_q && a && !m_ce_q) begin
        if (m_oe_q) begin m_lo = m_ad_q; s = 1'b1; end
        else m_hi = m_ad_q[9:0];
      end
    end else if (!c && !a) begin
      if (o) begin m_lo = d; s = 1'b1; end
      else m_hi = d[9:0];
    end
    m_adv_q = a; m_oe_q = o; m_ce_q = c; m_ad_q = d;
    e.addr = {m_hi, m_lo}; e.sense = s; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, addr, sense, e.addr, e.sense);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: addr=%h sense=%b expected completion", addr, sense);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", addr, sense, '0, 1'b0);
    rst_ni = 1'b1;
    cyc(1, 1, 1, 16'h0000, "R1 after release");

    // synchronous mode
    cfg = 16'h7FFF;
    cyc(0, 0, 0, 16'hFDAB, "R2 upper load drops high pins");
    cyc(0, 1, 0, 16'hBEEF, "R4 back-to-back lower, R3 sense");
    cyc(1, 1, 0, 16'h0000, "R10 sense low after pulse");
    cyc(0, 1, 0, 16'h1234, "R7 single lower keeps upper");
    cyc(1, 1, 0, 16'h1234, "R10 idle");
    cyc(0, 0, 1, 16'h0155, "R8 ce high upper ignored");
    cyc(0, 1, 1, 16'h4321, "R8 ce high lower ignored");
    cyc(1, 1, 1, 16'h0000, "R8 idle");
    cyc(0, 0, 0, 16'h0001, "R2 upper alone");
    cyc(1, 1, 0, 16'hAAAA, "R3 no lower without adv");

    // asynchronous mode
    cfg = 16'h8000;
    cyc(0, 0, 0, 16'h02AA, "R9 adv low no capture");
    cyc(0, 0, 0, 16'h02AA, "R9 adv still low");
    cyc(1, 1, 0, 16'hFFFF, "R5 upper on adv rise");
    cyc(0, 1, 0, 16'h5678, "R9 lower pending");
    cyc(1, 0, 0, 16'h0000, "R6 lower on rise with sense, R5");
    cyc(1, 1, 0, 16'h0000, "R10 async sense single");
    cyc(0, 1, 0, 16'h9ABC, "R9 single lower pending");
    cyc(1, 1, 0, 16'h0000, "R7 async single lower keeps upper");
    cyc(0, 0, 1, 16'h0333, "R8 async ce high");
    cyc(1, 0, 0, 16'h0000, "R8 async rise ignored");
    cyc(1, 1, 0, 16'h0000, "R10 async idle");

    @(posedge clk); #2;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 mid-run reset", addr, sense, '0, 1'b0);
    model_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    cfg = 16'h0000;
    cyc(1, 1, 0, 16'h0000, "R1 held after release");
    @(posedge clk); #2;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule